// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This controller runs an integrating dual-slope converter through an endless loop of measurement cycles. Each cycle has four phases: a loop-closed offset cancellation (auto-zero), a fixed-length integration of the input, a reference ramp back toward zero (deintegrate), and a clean-up phase that empties the integrator. The block drives one switch-control output per phase, plus a reference-polarity output. The analog parts (integrator, capacitors, buffer, comparator) are outside the block and only its comparator output comes back in.

The comparator output passes through a two-flop synchronizer. The synchronized value at the end of integration is stored as the input sign. During deintegrate, clocks are counted until the comparator reports the zero crossing. The block subtracts the synchronizer delay from the count. The result is a sign and a magnitude of up to 20000 counts, which equals 10000 × input/reference, so full scale is an input of twice the reference. If no crossing appears, the block flags over-range, saturates the result and stretches the following zeroing phase.

Top module: `dslope_seq`

## Requirements
- R1: Phases run in a fixed loop and are reported on `phase`: 0 auto-zero, 1 integrate, 2 deintegrate, 3 zeroing, then back to 0. After reset is released, auto-zero lasts `AZ_CLKS` clocks and integrate lasts `INT_CLKS` clocks.
- R2: Exactly one switch control is high, and it follows the phase. `az_close` is high in phase 0, `sel_sig` in phase 1, `sel_ref` in phase 2 and `zero_close` in phase 3.
- R3: The raw comparator level held through integration sets the sign. A high level means a positive input, which gives `result_neg`=0 and `ref_neg`=1 throughout deintegrate. A low level means a negative input, which gives `result_neg`=1 and `ref_neg`=0.
- R4: Deintegrate clocks are numbered from k=0. If the raw comparator first differs from the stored sign when sampled at clock k=N, with 0 ≤ N < `FULL_CNT`, then `result_mag`=N, `over_range`=0, and deintegrate lasts N+3 clocks. Comparator changes that happen during integration do not appear as a crossing.
- R5: A crossing first seen at k=`FULL_CNT` still gives `result_mag`=`FULL_CNT` with `over_range`=0.
- R6: If no crossing is seen at any k from 0 to `FULL_CNT`, then deintegrate ends after `FULL_CNT`+3 clocks with `over_range`=1 and `result_mag`=`FULL_CNT`.
- R7: `result_valid` is a one-clock pulse. It is high in the first zeroing clock. The sign, magnitude and over-range outputs change only together with that pulse and hold their values in between.
- R8: Zeroing lasts `ZERO_SHORT` clocks after an in-range result and `ZERO_LONG` clocks after an over-range result.
- R9: A synchronous active-high `rst` forces phase 0 with only `az_close` high, and clears `result_valid`, `result_neg`, `result_mag` and `over_range`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | 1 | Asynchronous comparator output |
| phase | output | 2 | Current phase code |
| az_close | output | 1 | Auto-zero loop close, inputs tied to common |
| sel_sig | output | 1 | Input terminals routed to the integrator |
| sel_ref | output | 1 | Reference capacitor routed to the integrator |
| ref_neg | output | 1 | Reference polarity during deintegrate |
| zero_close | output | 1 | Integrator zeroing loop close |
| result_valid | output | 1 | One-clock result strobe |
| result_neg | output | 1 | Sign of the held result |
| result_mag | output | MAG_W | Held result magnitude in counts |
| over_range | output | 1 | Held over-range flag |

## Verification
Two decisions can fall in the same deintegrate clock: the crossing detect and the count limit. This happens when the crossing arrives at exactly k=`FULL_CNT`. The bench provokes it by switching the comparator on that clock. It expects an in-range full-scale result, a deintegrate length of `FULL_CNT`+3 clocks and a short zeroing phase. It compares these against a run with no crossing at all, which must give the same magnitude but with the over-range flag set and the long zeroing phase.

// File: rtl/dslope_seq.sv
module dslope_seq #(
  parameter int AZ_CLKS    = 10000,
  parameter int INT_CLKS   = 10000,
  parameter int FULL_CNT   = 20000,
  parameter int ZERO_SHORT = 150,
  parameter int ZERO_LONG  = 6200,
  parameter int MAG_W      = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_in,
  output logic [1:0]       phase,
  output logic             az_close,
  output logic             sel_sig,
  output logic             sel_ref,
  output logic             ref_neg,
  output logic             zero_close,
  output logic             result_valid,
  output logic             result_neg,
  output logic [MAG_W-1:0] result_mag,
  output logic             over_range
);
  localparam int M1    = AZ_CLKS > INT_CLKS ? AZ_CLKS : INT_CLKS;
  localparam int M2    = M1 > FULL_CNT + 3 ? M1 : FULL_CNT + 3;
  localparam int CMAX  = M2 > ZERO_LONG ? M2 : ZERO_LONG;
  localparam int CNT_W = $clog2(CMAX + 1);

  localparam logic [1:0] PH_AZ = 2'd0, PH_INT = 2'd1, PH_DE = 2'd2, PH_ZERO = 2'd3;

  logic [1:0]       sync;
  logic             pos;
  logic             long_zero;
  logic [CNT_W-1:0] cnt;
  logic             last;

  wire cmp_s   = sync[1];
  // first two deintegrate samples still carry integrate-phase levels
  wire crossed = (cmp_s != pos) && (cnt >= CNT_W'(2));
  wire at_lim  = cnt == CNT_W'(FULL_CNT + 2);
  wire [CNT_W-1:0] zero_len = long_zero ? CNT_W'(ZERO_LONG) : CNT_W'(ZERO_SHORT);

  assign az_close   = phase == PH_AZ;
  assign sel_sig    = phase == PH_INT;
  assign sel_ref    = phase == PH_DE;
  assign zero_close = phase == PH_ZERO;
  assign ref_neg    = sel_ref & pos;

  always_comb begin
    case (phase)
      PH_AZ:   last = cnt == CNT_W'(AZ_CLKS - 1);
      PH_INT:  last = cnt == CNT_W'(INT_CLKS - 1);
      PH_DE:   last = crossed | at_lim;
      default: last = cnt == zero_len - CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync         <= '0;
      pos          <= 1'b0;
      long_zero    <= 1'b0;
      cnt          <= '0;
      phase        <= PH_AZ;
      result_valid <= 1'b0;
      result_neg   <= 1'b0;
      result_mag   <= '0;
      over_range   <= 1'b0;
    end else begin
      sync         <= {sync[0], cmp_in};
      result_valid <= 1'b0;
      if (last) begin
        cnt   <= '0;
        phase <= phase + 2'd1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      if (phase == PH_INT && last) pos <= cmp_s;
      if (phase == PH_DE && last) begin
        result_valid <= 1'b1;
        result_neg   <= ~pos;
        over_range   <= ~crossed;
        long_zero    <= ~crossed;
        result_mag   <= crossed ? MAG_W'(cnt - CNT_W'(2)) : MAG_W'(FULL_CNT);
      end
    end
  end
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
  parameter int FULL_CNT = 20000,
  parameter int MAG_W    = 15
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       phase,
  input logic             result_valid,
  input logic             result_neg,
  input logic             over_range,
  input logic [MAG_W-1:0] result_mag
);
  a_r1_phase_order: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && phase != $past(phase)) |-> phase == 2'($past(phase) + 2'd1));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !result_valid) |->
      ($stable(result_mag) && $stable(result_neg) && $stable(over_range)));

  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    over_range |-> result_mag == MAG_W'(FULL_CNT));

  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    result_mag <= MAG_W'(FULL_CNT));

  a_r7_valid_in_zero: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> phase == 2'd3);
endmodule

bind dslope_seq dslope_seq_chk #(.FULL_CNT(FULL_CNT), .MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .result_valid(result_valid),
  .result_neg(result_neg), .over_range(over_range), .result_mag(result_mag)
);

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
  localparam int AZ = 8, INT = 20, FULL = 40, ZS = 5, ZL = 30, MW = 15;

  logic clk = 1'b0, rst = 1'b1, cmp_in = 1'b0;
  logic [1:0] phase;
  logic az_close, sel_sig, sel_ref, ref_neg, zero_close;
  logic result_valid, result_neg, over_range;
  logic [MW-1:0] result_mag;

  int checks = 0, errors = 0;

  typedef struct { bit neg; bit ovr; int mag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  dslope_seq #(.AZ_CLKS(AZ), .INT_CLKS(INT), .FULL_CNT(FULL),
               .ZERO_SHORT(ZS), .ZERO_LONG(ZL), .MAG_W(MW)) u_dut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .phase(phase), .az_close(az_close),
    .sel_sig(sel_sig), .sel_ref(sel_ref), .ref_neg(ref_neg), .zero_close(zero_close),
    .result_valid(result_valid), .result_neg(result_neg),
    .result_mag(result_mag), .over_range(over_range));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: one conversion; n < 0 means no crossing at all
  task automatic conv(input bit positive, input int n);
    exp_t e;
    while (phase != 2'd0) @(negedge clk);
    cmp_in = positive;
    while (phase != 2'd2) @(negedge clk);
    chk(ref_neg == positive, "R3 ref_neg", ref_neg, positive);
    e.neg = !positive;
    e.ovr = (n < 0);
    e.mag = (n < 0) ? FULL : n;
    q.push_back(e);
    if (n >= 0) begin
      repeat (n) @(negedge clk);
      cmp_in = !positive;
    end
    while (phase == 2'd2) @(negedge clk);
  endtask

  // monitor
  logic [1:0] prev = 2'd0;
  int run = 0;
  bit first = 1'b1, had = 1'b0, prev_valid = 1'b0;
  exp_t cur, held;

  always @(negedge clk) begin
    if (rst) begin
      prev = 2'd0; run = 0; first = 1'b1; prev_valid = 1'b0;
    end else begin
      if (result_valid) begin
        chk(!prev_valid, "R7 pulse width", 2, 1);
        if (q.size() == 0) chk(1'b0, "R4 unexpected result", result_mag, -1);
        else begin
          cur = q.pop_front();
          chk(result_mag == cur.mag, "R4/R5/R6 magnitude", result_mag, cur.mag);
          chk(result_neg == cur.neg, "R3 sign", result_neg, cur.neg);
          chk(over_range == cur.ovr, "R6 over_range", over_range, cur.ovr);
          held = cur; had = 1'b1;
        end
      end
      prev_valid = result_valid;
      if (phase != prev) begin
        case (prev)
          2'd0: begin
            if (!first) chk(run == AZ, "R1 auto-zero length", run, AZ);
            first = 1'b0;
          end
          2'd1: chk(run == INT, "R1 integrate length", run, INT);
          2'd2: chk(run == (cur.ovr ? FULL + 3 : cur.mag + 3), "R4/R6 deintegrate length",
                    run, cur.ovr ? FULL + 3 : cur.mag + 3);
          default: chk(run == (cur.ovr ? ZL : ZS), "R8 zeroing length", run, cur.ovr ? ZL : ZS);
        endcase
        chk({az_close, sel_sig, sel_ref, zero_close} == (4'b1000 >> phase),
            "R2 switch controls", {az_close, sel_sig, sel_ref, zero_close}, 4'b1000 >> phase);
        if (phase == 2'd2 && had)
          chk(result_mag == held.mag && result_neg == held.neg && over_range == held.ovr,
              "R7 result hold", result_mag, held.mag);
        prev = phase;
        run = 1;
      end else begin
        run++;
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      chk(1'b0, "watchdog", wd, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phase == 2'd0 && az_close && !sel_sig && !sel_ref && !zero_close, "R9 reset phase", phase, 0);
    chk(!result_valid && result_mag == 0 && !over_range && !result_neg, "R9 reset result", result_mag, 0);
    rst = 1'b0;
    conv(1'b1, 7);
    conv(1'b0, 13);
    conv(1'b1, 0);
    conv(1'b0, FULL);   // R5: crossing and limit in the same clock
    conv(1'b1, -1);     // R6: over-range
    conv(1'b0, 3);      // R8: long zeroing after over-range
    conv(1'b1, FULL - 1);
    while (phase != 2'd0) @(negedge clk);
    chk(q.size() == 0, "R7 all results seen", q.size(), 0);
    // R9: reset in the middle of deintegrate
    cmp_in = 1'b1;
    while (phase != 2'd2) @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(phase == 2'd0 && az_close && !sel_ref && !ref_neg, "R9 mid-run reset phase", phase, 0);
    chk(!result_valid && result_mag == 0 && !over_range && !result_neg, "R9 mid-run reset result",
        result_mag, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule